// File: doc/BRIEF.md
# Per-Channel Transmit Low-Watermark Store with Indirect Host Access

This block keeps one 9-bit transmit low-watermark for each HDLC channel in a small internal RAM. The host never addresses the RAM directly. It uses two 16-bit registers instead. The access-control register holds a channel number and a direction bit, and writing it starts a fixed-length RAM transaction. The value register supplies the word for a store or receives the word from a fetch. A busy bit in the access-control register stays set while a transaction is running, and the host polls it before it reads the result or starts the next access.

Alongside the host path, a lookup stream compares a channel's remaining FIFO block count with the watermark stored for that channel. The lookup checks the watermark against the channel's linked-chain length, and it raises a refill request only when the setting is legal. The lookup input uses valid/ready signalling: a lookup is accepted on a clock edge where `cmp_valid` and `cmp_ready` are both high. Ready drops while a host transaction holds the RAM, and also in the cycle an access-control write arrives, so the host always takes precedence. The caller must hold its lookup until ready returns. The result is a single-cycle pulse on the following edge, and it has no back-pressure.

Top module: `lwm_indirect_store`

## Requirements
- R1: After reset, both registers read 0x0000, the busy bit is clear, no result is valid and every stored watermark is 0.
- R2: The access-control register sits at offset 0x9A0. When read it returns the channel number in bits 5:0, the direction in bit 14 (1 = fetch, 0 = store) and busy in bit 15, with every other bit 0. Channel code 0x00 is the first channel and 0x27 is the fortieth. Reading any offset other than 0x9A0 or 0x9A4 returns 0.
- R3: A write to the access-control register while busy is clear sets busy at the next edge. Busy then stays high for exactly 3 cycles, and it clears at the edge where the transaction commits.
- R4: A store writes value-register bits 8:0 into the selected channel's slot. A fetch loads that slot into the value register, which sits at offset 0x9A4. Value-register bits 15:9 are ignored on write and read as 0.
- R5: A write to the access-control register while busy is set is ignored. The channel and direction stay the same, and no new transaction starts.
- R6: A write to the value register while busy is set is ignored.
- R7: For channel codes above 0x27, a fetch returns 0 and a store changes no slot.
- R8: An accepted lookup produces `res_valid` on the next edge. `res_req` is 1 when the block count is less than or equal to the stored watermark W, provided 1 <= W <= chain length - 2.
- R9: A stored watermark of 0 gives neither a request nor an error.
- R10: A non-zero watermark with W > chain length - 2 gives `res_err` = 1 and `res_req` = 0.
- R11: `cmp_ready` is low while busy is set, and also in any cycle with a write to the access-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| cmp_valid | input | 1 | Lookup request valid |
| cmp_ready | output | 1 | Lookup can be accepted |
| cmp_ch | input | 6 | Lookup channel code |
| cmp_left | input | 9 | Remaining FIFO blocks for the channel |
| cmp_len | input | 10 | Linked-chain length in blocks |
| res_valid | output | 1 | Lookup result pulse |
| res_req | output | 1 | Refill request |
| res_err | output | 1 | Watermark out of range for the chain |

## Verification
The bench builds the block with its default parameters: 40 channels, a 6-bit channel code, 9-bit watermarks and a 3-cycle access. With these values every one of the 64 channel codes can be covered, including the 24 codes that map to no slot. Each slot gets its own watermark from an arithmetic pattern, and slot 0 holds 0. Each slot is then read back, and lookups are swept over both sides of the block-count threshold and both sides of the chain-length limit. Busy timing, the writes that are ignored during a transaction, and the ready handling when a lookup collides with the host are each checked cycle by cycle.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  typedef enum logic {
    DIR_STORE = 1'b0,
    DIR_FETCH = 1'b1
  } acc_dir_e;

  localparam int REG_W      = 16;
  localparam int BUSY_BIT   = 15;
  localparam int DIR_BIT    = 14;
endpackage

// File: rtl/lwm_host_seq.sv
module lwm_host_seq
  import lwm_pkg::*;
#(
  parameter int CH_W    = 6,
  parameter int WM_W    = 9,
  parameter int ACC_LAT = 3,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] SEL_OFF = 12'h9A0,
  parameter logic [ADDR_W-1:0] DAT_OFF = 12'h9A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              busy,
  output logic              sel_hit,
  output logic [CH_W-1:0]   sel_ch,
  input  logic [WM_W-1:0]   ram_rdata,
  output logic              ram_we,
  output logic [WM_W-1:0]   ram_wdata
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

  acc_dir_e         dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WM_W-1:0]  data_q;
  logic             dat_hit;

  assign sel_hit = host_wr && (host_addr == SEL_OFF);
  assign dat_hit = host_wr && (host_addr == DAT_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      sel_ch <= '0;
      dir_q  <= DIR_STORE;
      data_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy <= 1'b0;
        if (dir_q == DIR_FETCH) data_q <= ram_rdata;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      if (sel_hit) begin
        sel_ch <= host_wdata[CH_W-1:0];
        dir_q  <= acc_dir_e'(host_wdata[DIR_BIT]);
        busy   <= 1'b1;
        cnt_q  <= CNT_W'(ACC_LAT - 1);
      end
      if (dat_hit) data_q <= host_wdata[WM_W-1:0];
    end
  end

  assign ram_we    = busy && (cnt_q == '0) && (dir_q == DIR_STORE);
  assign ram_wdata = data_q;

  always_comb begin
    host_rdata = '0;
    if (host_addr == SEL_OFF) begin
      host_rdata[BUSY_BIT]  = busy;
      host_rdata[DIR_BIT]   = dir_q;
      host_rdata[CH_W-1:0]  = sel_ch;
    end else if (host_addr == DAT_OFF) begin
      host_rdata[WM_W-1:0]  = data_q;
    end
  end
endmodule

// File: rtl/lwm_ram.sv
module lwm_ram #(
  parameter int NUM_CH = 40,
  parameter int CH_W   = 6,
  parameter int WM_W   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] waddr,
  input  logic [WM_W-1:0] wdata,
  input  logic [CH_W-1:0] raddr_a,
  output logic [WM_W-1:0] rdata_a,
  input  logic [CH_W-1:0] raddr_b,
  output logic [WM_W-1:0] rdata_b
);
  logic [WM_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < NUM_CH)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < NUM_CH) ? mem[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < NUM_CH) ? mem[raddr_b] : '0;
endmodule

// File: rtl/lwm_cmp.sv
module lwm_cmp #(
  parameter int WM_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [WM_W-1:0] wm,
  input  logic [WM_W-1:0] left,
  input  logic [WM_W:0]   chain_len,
  output logic            res_valid,
  output logic            res_req,
  output logic            res_err
);
  localparam int LEN_W = WM_W + 1;

  logic [LEN_W-1:0] lim;
  logic             nz, fits;

  assign lim  = {1'b0, wm} + LEN_W'(2);
  assign nz   = (wm != '0);
  assign fits = nz && (lim <= chain_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_req   <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= fire;
      res_req   <= fire && fits && (left <= wm);
      res_err   <= fire && nz && !fits;
    end
  end
endmodule

// File: rtl/lwm_indirect_store.sv
module lwm_indirect_store
  import lwm_pkg::*;
#(
  parameter int NUM_CH  = 40,
  parameter int CH_W    = 6,
  parameter int WM_W    = 9,
  parameter int ACC_LAT = 3,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] SEL_OFF = 12'h9A0,
  parameter logic [ADDR_W-1:0] DAT_OFF = 12'h9A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [CH_W-1:0]   cmp_ch,
  input  logic [WM_W-1:0]   cmp_left,
  input  logic [WM_W:0]     cmp_len,
  output logic              res_valid,
  output logic              res_req,
  output logic              res_err
);
  logic            busy_w, sel_hit_w, ram_we_w;
  logic [CH_W-1:0] sel_ch_w;
  logic [WM_W-1:0] host_rd_w, cmp_rd_w, ram_wd_w;

  lwm_host_seq #(
    .CH_W(CH_W), .WM_W(WM_W), .ACC_LAT(ACC_LAT), .ADDR_W(ADDR_W),
    .SEL_OFF(SEL_OFF), .DAT_OFF(DAT_OFF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy_w), .sel_hit(sel_hit_w), .sel_ch(sel_ch_w),
    .ram_rdata(host_rd_w), .ram_we(ram_we_w), .ram_wdata(ram_wd_w)
  );

  lwm_ram #(.NUM_CH(NUM_CH), .CH_W(CH_W), .WM_W(WM_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we_w), .waddr(sel_ch_w), .wdata(ram_wd_w),
    .raddr_a(sel_ch_w), .rdata_a(host_rd_w),
    .raddr_b(cmp_ch), .rdata_b(cmp_rd_w)
  );

  assign cmp_ready = !busy_w && !sel_hit_w;

  lwm_cmp #(.WM_W(WM_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .fire(cmp_valid && cmp_ready),
    .wm(cmp_rd_w), .left(cmp_left), .chain_len(cmp_len),
    .res_valid(res_valid), .res_req(res_req), .res_err(res_err)
  );
endmodule

// File: rtl/lwm_checker.sv
module lwm_checker #(
  parameter int CH_W    = 6,
  parameter int ACC_LAT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            sel_hit,
  input logic [CH_W-1:0] sel_ch,
  input logic            cmp_valid,
  input logic            cmp_ready,
  input logic            res_valid,
  input logic            res_req,
  input logic            res_err
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 8'd1;
    else           busy_cnt <= '0;
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !busy) |=> busy);

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 8'(ACC_LAT)));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 8'(ACC_LAT)));

  assert_ignore_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_hit) |=> $stable(sel_ch));

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || sel_hit) |-> !cmp_ready);

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready) |=> res_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && cmp_ready) |=> !res_valid);

  assert_req_excl_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_req |-> !res_err);
endmodule

bind lwm_indirect_store lwm_checker #(.CH_W(CH_W), .ACC_LAT(ACC_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .sel_hit(sel_hit_w),
  .sel_ch(sel_ch_w), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
  .res_valid(res_valid), .res_req(res_req), .res_err(res_err)
);

// File: tb/lwm_indirect_store_test.sv
`timescale 1ns/1ps
module lwm_indirect_store_test;
  localparam logic [11:0] SEL = 12'h9A0;
  localparam logic [11:0] DAT = 12'h9A4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [5:0]  cmp_ch = '0;
  logic [8:0]  cmp_left = '0;
  logic [9:0]  cmp_len = '0;
  logic        res_valid, res_req, res_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lwm_indirect_store uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_ch(cmp_ch),
    .cmp_left(cmp_left), .cmp_len(cmp_len),
    .res_valid(res_valid), .res_req(res_req), .res_err(res_err)
  );

  function automatic logic [8:0] wm_of(int c);
    return 9'((c * 13) % 512);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [11:0] a, logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [11:0] a, output logic [15:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic access(logic [15:0] sel);
    hwrite(SEL, sel);
    repeat (3) @(negedge clk);
  endtask

  task automatic lookup(int c, int left, int len);
    logic [8:0] w;
    bit fits, er, rq;
    w    = (c < 40) ? wm_of(c) : 9'd0;
    fits = (w != 0) && (int'(w) + 2 <= len);
    er   = (w != 0) && !fits;
    rq   = fits && (left <= int'(w));
    cmp_valid = 1'b1; cmp_ch = 6'(c); cmp_left = 9'(left); cmp_len = 10'(len);
    #0.5;
    chk(cmp_ready == 1'b1, "R11 ready idle", cmp_ready, 1);
    @(negedge clk);
    cmp_valid = 1'b0;
    chk(res_valid == 1'b1, "R8 valid", res_valid, 1);
    if (w == 0)
      chk(res_req == 0 && res_err == 0, "R9 zero wm", {res_req, res_err}, 0);
    else if (er)
      chk(res_req == 0 && res_err == 1, "R10 range", {res_req, res_err}, 1);
    else
      chk(res_req == rq && res_err == 0, "R8 req", {res_req, res_err}, {rq, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(SEL, rd); chk(rd == 16'h0000, "R1 sel reset", rd, 0);
    hread(DAT, rd); chk(rd == 16'h0000, "R1 data reset", rd, 0);
    chk(res_valid == 0, "R1 no result", res_valid, 0);
    hread(12'h9A8, rd); chk(rd == 16'h0000, "R2 unmapped offset", rd, 0);
    // R1 slots cleared: fetch channel 7 gives 0
    access(16'h4007);
    hread(DAT, rd); chk(rd == 16'h0000, "R1 slot reset", rd, 0);

    // store sweep, R4 with reserved bits set
    for (int c = 0; c < 40; c++) begin
      hwrite(DAT, 16'hFE00 | 16'(wm_of(c)));
      if (c == 0) begin
        hwrite(SEL, 16'h0000);
        for (int k = 0; k < 3; k++) begin
          hread(SEL, rd); chk(rd[15] == 1'b1, "R3 busy high", rd[15], 1);
          if (k == 1) begin
            cmp_valid = 1'b1; cmp_ch = 6'd3;
            #0.5; chk(cmp_ready == 1'b0, "R11 ready busy", cmp_ready, 0);
          end
          @(negedge clk);
          cmp_valid = 1'b0;
          if (k == 1) chk(res_valid == 0, "R11 no accept", res_valid, 0);
        end
        hread(SEL, rd); chk(rd[15] == 1'b0, "R3 busy clear", rd[15], 0);
      end else if (c == 5) begin
        hwrite(SEL, 16'h0005);
        hwrite(SEL, 16'h4009);
        hwrite(DAT, 16'h0077);
        @(negedge clk);
        hread(SEL, rd); chk(rd == 16'h0005, "R5 sel ignored", rd, 16'h0005);
        hread(DAT, rd); chk(rd == 16'(wm_of(5)), "R6 data ignored", rd, wm_of(5));
      end else begin
        access(16'(c));
      end
    end
    hread(DAT, rd); chk(rd == 16'(wm_of(39)), "R4 reserved read 0", rd, wm_of(39));

    // R7 out-of-range stores
    hwrite(DAT, 16'h01AB);
    for (int c = 40; c < 64; c++) access(16'(c));

    // fetch sweep over all codes
    for (int c = 0; c < 64; c++) begin
      logic [15:0] exp;
      hwrite(DAT, 16'h0155);
      access(16'h4000 | 16'(c));
      exp = (c < 40) ? 16'(wm_of(c)) : 16'h0000;
      hread(DAT, rd);
      if (c < 40) chk(rd == exp, "R4 fetch", rd, exp);
      else        chk(rd == exp, "R7 fetch", rd, exp);
      hread(SEL, rd); chk(rd == (16'h4000 | 16'(c)), "R2 sel layout", rd, 16'h4000 | 16'(c));
    end

    // R11 same-cycle select write
    host_wr = 1'b1; host_addr = SEL; host_wdata = 16'h4001;
    cmp_valid = 1'b1; cmp_ch = 6'd1;
    #0.5; chk(cmp_ready == 1'b0, "R11 ready on sel write", cmp_ready, 0);
    @(negedge clk);
    host_wr = 1'b0; cmp_valid = 1'b0;
    chk(res_valid == 0, "R11 host priority", res_valid, 0);
    repeat (3) @(negedge clk);

    // lookup sweep: R8 R9 R10
    for (int c = 0; c < 44; c++) begin
      int w;
      w = (c < 40) ? int'(wm_of(c)) : 0;
      lookup(c, w, w + 2);
      lookup(c, w + 1, w + 2);
      lookup(c, (w > 0) ? w - 1 : 0, w + 3);
      lookup(c, 0, w + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule